// File: doc/BRIEF.md
# Three-Stage Frame-Synchronized Serial Receiver

This block is the receiving side of a frame-synchronized serial port. A sample enable marks each active edge of the receive bit clock, which is modelled as a one-cycle strobe in the system clock domain. A frame-sync seen on a sampled edge starts a word. After a programmable number of bit slots, the data bits are shifted in most significant bit first.

A completed word moves through three stages: a shift stage, a holding buffer and a data stage that software can read. A word advances only when the stage in front of it is empty. While a word is copied from the buffer into the data stage, it is reshaped in one of two ways: an 8-bit mu-law or A-law code is expanded into a 16-bit linear sample, or the word is justified and filled. The data stage is read as a low half and a high half of 16 bits each. A strobe that reads the low half empties the data stage, and that frees the buffer to advance.

Top module: `tsrx_receiver`

## Requirements
- R1: Data is sampled only on cycles where `rx_sample_en` is 1. On a sampled cycle with `rx_fsync`=1, a new frame starts. The first data bit is taken k sampled cycles after the frame-sync sample: `cfg_delay` 0, 1 or 2 gives k=0, 1 or 2, and code 3 acts as 2. Bits arrive MSB first.
- R2: `cfg_wlen` selects the word length: code 0 is 8 bits, 1 is 12, 2 is 16, 3 is 20, 4 is 24 and 5 is 32. Codes 6 and 7 act as 32.
- R3: A finished word enters the buffer only if the buffer is empty. If the buffer is full, the word is discarded and `rx_overrun` is set. `rx_overrun` stays set until reset or an `ovr_clear` strobe. A new overrun in the same cycle as a clear takes precedence.
- R4: The buffer moves to the data stage on the first clock where the data stage is empty. That clock sets `rx_ready`, so `rx_ready` rises two clocks after the sample that carries the last bit, when the stages are empty.
- R5: A `rd_lo` strobe while `rx_ready` is 1 clears `rx_ready` on that clock. A waiting buffered word is copied on the next clock. `rd_lo` while `rx_ready` is 0 has no effect.
- R6: `cfg_compand` 10b expands the low 8 bits of the buffered word as mu-law, and 11b expands them as A-law. Either way, the signed 16-bit linear value goes to `dout_lo` and `dout_hi` is 0. Codes 00b and 01b select no expansion.
- R7: With no expansion, the word of n bits is reshaped by `cfg_just`. 00b and 11b right-justify it with zero fill. 01b right-justifies it with sign extension from bit n-1. 10b left-justifies it with zero fill in the low bits. For n≤16 the result is 16 bits in `dout_lo` and `dout_hi` is 0. For n>16 the result is 32 bits, with `dout_hi` holding bits 31:16.
- R8: `dout_hi` and `dout_lo` change only when a copy into the data stage occurs. After the low half is read, the next copy overwrites the high half, so the high half must be read first.
- R9: A frame-sync during a word abandons the partial word and restarts reception.
- R10: After reset, `rx_ready`, `rx_overrun`, `dout_lo` and `dout_hi` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sample_en | input | 1 | Strobe marking a receive bit-clock sampling edge |
| rx_fsync | input | 1 | Frame-sync, qualified by the sample strobe |
| rx_data | input | 1 | Serial data input |
| cfg_wlen | input | 3 | Word length code |
| cfg_delay | input | 2 | Data delay in bit slots |
| cfg_compand | input | 2 | Expansion select |
| cfg_just | input | 2 | Justification and fill select |
| rd_lo | input | 1 | Read strobe for the low data half |
| ovr_clear | input | 1 | Clears the overrun flag |
| dout_lo | output | 16 | Low half of the data stage |
| dout_hi | output | 16 | High half of the data stage |
| rx_ready | output | 1 | Data stage holds an unread word |
| rx_overrun | output | 1 | Sticky overrun flag |

## Verification
Words are sent with every delay code and every length code, using bit patterns with the sign bit set and with it clear, so that sign extension can be told apart from zero fill, and left justification from right justification. Filler bits during the delay are driven as 1, and the data line is inverted between samples, so that a wrong sampling slot or a missing enable gate shows up in the value. Companding codes are chosen at both extremes of each law. Three back-to-back words without reads check the overrun drop, and two 32-bit words check read ordering. A frame-sync in the middle of a word is sent to check the restart.

// File: rtl/tsrx_pkg.sv
package tsrx_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int CNT_W  = $clog2(WORD_W) + 1;

  typedef enum logic [1:0] {
    JUST_RZERO = 2'b00,
    JUST_RSIGN = 2'b01,
    JUST_LZERO = 2'b10,
    JUST_RSVD  = 2'b11
  } just_e;

  function automatic logic [CNT_W-1:0] len_of(input logic [2:0] code);
    case (code)
      3'd0:    return CNT_W'(8);
      3'd1:    return CNT_W'(12);
      3'd2:    return CNT_W'(16);
      3'd3:    return CNT_W'(20);
      3'd4:    return CNT_W'(24);
      default: return CNT_W'(32);
    endcase
  endfunction

  function automatic logic [HALF_W-1:0] mulaw_expand(input logic [7:0] code);
    logic [7:0]  c;
    logic [16:0] t;
    logic [15:0] mag;
    c   = ~code;
    t   = ({10'd0, c[3:0], 3'b000} + 17'h84) << c[6:4];
    mag = t[15:0] - 16'h84;
    return c[7] ? (16'h0 - mag) : mag;
  endfunction

  function automatic logic [HALF_W-1:0] alaw_expand(input logic [7:0] code);
    logic [7:0]  a;
    logic [16:0] t;
    a = code ^ 8'h55;
    t = {9'd0, a[3:0], 4'b0000};
    if (a[6:4] == 3'd0) t = t + 17'd8;
    else                t = (t + 17'h108) << (a[6:4] - 3'd1);
    return a[7] ? t[15:0] : (16'h0 - t[15:0]);
  endfunction

  function automatic logic [WORD_W-1:0] format_word(input logic [WORD_W-1:0] w,
                                                    input logic [2:0] wl,
                                                    input logic [1:0] comp,
                                                    input logic [1:0] just);
    logic [CNT_W-1:0]  n;
    logic [WORD_W-1:0] r;
    n = len_of(wl);
    if (comp == 2'b10) begin
      r = {{HALF_W{1'b0}}, mulaw_expand(w[7:0])};
    end else if (comp == 2'b11) begin
      r = {{HALF_W{1'b0}}, alaw_expand(w[7:0])};
    end else begin
      case (just_e'(just))
        JUST_RSIGN: begin
          r = w;
          if (w[n - 1'b1]) r = w | ({WORD_W{1'b1}} << n);
          if (n <= CNT_W'(HALF_W)) r = {{HALF_W{1'b0}}, r[HALF_W-1:0]};
        end
        JUST_LZERO: begin
          if (n <= CNT_W'(HALF_W))
            r = {{HALF_W{1'b0}}, w[HALF_W-1:0] << (CNT_W'(HALF_W) - n)};
          else
            r = w << (CNT_W'(WORD_W) - n);
        end
        default: r = w;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/tsrx_deframer.sv
module tsrx_deframer
  import tsrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              fsync,
  input  logic              din,
  input  logic [2:0]        cfg_wlen,
  input  logic [1:0]        cfg_delay,
  output logic              word_done,
  output logic [WORD_W-1:0] word_val
);
  logic              active;
  logic [1:0]        skip;
  logic [CNT_W-1:0]  bits, n_lat;
  logic [WORD_W-1:0] acc;

  logic              start, take;
  logic [1:0]        k;
  logic [CNT_W-1:0]  n_now, bits_now;
  logic [WORD_W-1:0] acc_now;

  always_comb begin
    k        = (cfg_delay == 2'd3) ? 2'd2 : cfg_delay;
    start    = sample_en && fsync;
    n_now    = start ? len_of(cfg_wlen) : n_lat;
    bits_now = start ? '0 : bits;
    acc_now  = start ? '0 : acc;
    take     = start ? (k == 2'd0) : (sample_en && active && (skip == 2'd0));
    word_done = take && ((bits_now + 1'b1) == n_now);
    word_val  = {acc_now[WORD_W-2:0], din};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      skip   <= '0;
      bits   <= '0;
      n_lat  <= CNT_W'(8);
      acc    <= '0;
    end else if (start) begin
      active <= 1'b1;
      n_lat  <= n_now;
      skip   <= (k == 2'd0) ? 2'd0 : (k - 2'd1);
      bits   <= take ? CNT_W'(1) : '0;
      acc    <= take ? word_val : '0;
    end else if (sample_en && active) begin
      if (skip != 2'd0) begin
        skip <= skip - 2'd1;
      end else begin
        acc  <= word_val;
        bits <= bits + 1'b1;
        if (word_done) active <= 1'b0;
      end
    end
  end

  // R2
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (bits < n_lat));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && fsync && cfg_delay != 2'd0) |=> (active && bits == '0));
endmodule

// File: rtl/tsrx_buffer_stage.sv
module tsrx_buffer_stage
  import tsrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_done,
  input  logic [WORD_W-1:0] word_val,
  input  logic              pull,
  input  logic              ovr_clear,
  output logic              buf_full,
  output logic [WORD_W-1:0] buf_word,
  output logic              ovr_flag
);
  logic accept, drop;

  assign accept = word_done && !buf_full;
  assign drop   = word_done &&  buf_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      buf_word <= '0;
      ovr_flag <= 1'b0;
    end else begin
      if (accept) begin
        buf_full <= 1'b1;
        buf_word <= word_val;
      end else if (pull) begin
        buf_full <= 1'b0;
      end
      if (drop)           ovr_flag <= 1'b1;
      else if (ovr_clear) ovr_flag <= 1'b0;
    end
  end

  // R3
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && buf_full) |=> ovr_flag);

  // R3
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clear) |=> ovr_flag);

  // R3
  drop_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !pull) |=> $stable(buf_word));

  // R4
  pull_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull |=> !buf_full);
endmodule

// File: rtl/tsrx_data_stage.sv
module tsrx_data_stage
  import tsrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_full,
  input  logic [WORD_W-1:0] buf_word,
  input  logic [2:0]        cfg_wlen,
  input  logic [1:0]        cfg_compand,
  input  logic [1:0]        cfg_just,
  input  logic              rd_lo,
  output logic              copy_go,
  output logic              ready,
  output logic [HALF_W-1:0] lo,
  output logic [HALF_W-1:0] hi
);
  logic [WORD_W-1:0] shaped;

  assign copy_go = buf_full && !ready;
  assign shaped  = format_word(buf_word, cfg_wlen, cfg_compand, cfg_just);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready <= 1'b0;
      lo    <= '0;
      hi    <= '0;
    end else if (copy_go) begin
      ready <= 1'b1;
      lo    <= shaped[HALF_W-1:0];
      hi    <= shaped[WORD_W-1:HALF_W];
    end else if (rd_lo) begin
      ready <= 1'b0;
    end
  end

  // R4
  copy_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_go |=> ready);

  // R5
  read_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && ready) |=> !ready);

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_go |=> ($stable(hi) && $stable(lo)));

  // R6
  compand_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_go && cfg_compand[1]) |=> (hi == '0));
endmodule

// File: rtl/tsrx_receiver.sv
module tsrx_receiver
  import tsrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_sample_en,
  input  logic              rx_fsync,
  input  logic              rx_data,
  input  logic [2:0]        cfg_wlen,
  input  logic [1:0]        cfg_delay,
  input  logic [1:0]        cfg_compand,
  input  logic [1:0]        cfg_just,
  input  logic              rd_lo,
  input  logic              ovr_clear,
  output logic [HALF_W-1:0] dout_lo,
  output logic [HALF_W-1:0] dout_hi,
  output logic              rx_ready,
  output logic              rx_overrun
);
  logic              word_done;
  logic [WORD_W-1:0] word_val;
  logic              buf_full;
  logic [WORD_W-1:0] buf_word;
  logic              copy_go;

  tsrx_deframer u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (rx_sample_en),
    .fsync     (rx_fsync),
    .din       (rx_data),
    .cfg_wlen  (cfg_wlen),
    .cfg_delay (cfg_delay),
    .word_done (word_done),
    .word_val  (word_val)
  );

  tsrx_buffer_stage u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_done (word_done),
    .word_val  (word_val),
    .pull      (copy_go),
    .ovr_clear (ovr_clear),
    .buf_full  (buf_full),
    .buf_word  (buf_word),
    .ovr_flag  (rx_overrun)
  );

  tsrx_data_stage u_data (
    .clk         (clk),
    .rst_n       (rst_n),
    .buf_full    (buf_full),
    .buf_word    (buf_word),
    .cfg_wlen    (cfg_wlen),
    .cfg_compand (cfg_compand),
    .cfg_just    (cfg_just),
    .rd_lo       (rd_lo),
    .copy_go     (copy_go),
    .ready       (rx_ready),
    .lo          (dout_lo),
    .hi          (dout_hi)
  );

  // R4
  ready_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(buf_full));

  // R1
  idle_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_sample_en |-> !word_done);
endmodule

// File: tb/tsrx_receiver_tb.sv
`timescale 1ns/1ps
module tsrx_receiver_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 0, fs_i = 0, d_i = 0, rd_i = 0, clr_i = 0;
  logic [2:0] wlen_i = 3'd2;
  logic [1:0] dly_i = 2'd1, comp_i = 2'd0, just_i = 2'd0;
  logic [15:0] dout_lo, dout_hi;
  logic rx_ready, rx_overrun;

  int checks = 0, errors = 0;
  string cur_req = "R10";
  bit done_flag = 0;

  always #2 clk = ~clk;

  tsrx_receiver u_dut (
    .clk(clk), .rst_n(rst_n), .rx_sample_en(en_i), .rx_fsync(fs_i), .rx_data(d_i),
    .cfg_wlen(wlen_i), .cfg_delay(dly_i), .cfg_compand(comp_i), .cfg_just(just_i),
    .rd_lo(rd_i), .ovr_clear(clr_i), .dout_lo(dout_lo), .dout_hi(dout_hi),
    .rx_ready(rx_ready), .rx_overrun(rx_overrun));

  // ---------------- reference model ----------------
  bit     m_active, m_bfull, m_dfull, m_ovr;
  int     m_wait, m_n;
  bit     m_q[$];
  longint m_bword;
  longint m_lo, m_hi;

  function automatic int len_ref(int code);
    int tbl[8] = '{8, 12, 16, 20, 24, 32, 32, 32};
    return tbl[code];
  endfunction

  function automatic longint ref_format(longint w, int n, int comp, int just);
    longint v, code;
    int e, m, s;
    if (comp >= 2) begin
      code = w & 255;
      if (comp == 2) begin
        code = (~code) & 255;
        e = int'((code >> 4) & 7); m = int'(code & 15);
        v = 4 * ((longint'(2 * m + 33) << e) - 33);
        if (code >= 128) v = -v;
      end else begin
        code = code ^ 85;
        s = int'((code >> 4) & 7); m = int'(code & 15);
        v = (s == 0) ? 8 * (2 * m + 1) : 8 * (longint'(2 * m + 33) << (s - 1));
        if (code < 128) v = -v;
      end
      return v & 64'hFFFF;
    end
    if (just == 1) begin
      v = (w >= (64'd1 << (n - 1))) ? w - (64'd1 << n) : w;
    end else if (just == 2) begin
      v = (n <= 16) ? w * (64'd1 << (16 - n)) : w * (64'd1 << (32 - n));
    end else begin
      v = w;
    end
    return (n <= 16) ? (v & 64'hFFFF) : (v & 64'hFFFF_FFFF);
  endfunction

  always @(posedge clk) begin
    bit o_bfull, o_dfull, fin;
    longint val, f;
    o_bfull = m_bfull; o_dfull = m_dfull; fin = 0; val = 0;
    if (!rst_n) begin
      m_active = 0; m_bfull = 0; m_dfull = 0; m_ovr = 0;
      m_lo = 0; m_hi = 0; m_bword = 0; m_q.delete();
    end else begin
      if (en_i) begin
        if (fs_i) begin
          m_q.delete(); m_active = 1;
          m_wait = (dly_i >= 2) ? 2 : int'(dly_i);
          m_n = len_ref(int'(wlen_i));
        end
        if (m_active) begin
          if (m_wait == 0) begin
            m_q.push_back(d_i);
            if (m_q.size() == m_n) begin
              foreach (m_q[i]) val = val * 2 + longint'(m_q[i]);
              fin = 1; m_active = 0;
            end
          end else begin
            m_wait--;
          end
        end
      end
      if (o_bfull && !o_dfull) begin
        f = ref_format(m_bword, len_ref(int'(wlen_i)), int'(comp_i), int'(just_i));
        m_lo = f & 64'hFFFF; m_hi = (f >> 16) & 64'hFFFF;
        m_dfull = 1; m_bfull = 0;
      end else if (rd_i && o_dfull) begin
        m_dfull = 0;
      end
      if (fin && o_bfull) m_ovr = 1;
      else if (clr_i) m_ovr = 0;
      if (fin && !o_bfull) begin m_bfull = 1; m_bword = val; end
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk(cur_req, "ready",   longint'(rx_ready),   longint'(m_dfull));
      chk(cur_req, "overrun", longint'(rx_overrun), longint'(m_ovr));
      chk(cur_req, "dout_lo", longint'(dout_lo),    m_lo);
      chk(cur_req, "dout_hi", longint'(dout_hi),    m_hi);
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(int c);
    repeat (c) begin
      @(negedge clk);
      en_i = 0; fs_i = 0; rd_i = 0; clr_i = 0;
    end
  endtask

  task automatic slot(bit fs, bit d);
    @(negedge clk);
    en_i = 1; fs_i = fs; d_i = d; rd_i = 0; clr_i = 0;
    @(negedge clk);
    en_i = 0; fs_i = 0; d_i = ~d;
  endtask

  task automatic send(longint val, int n, int k);
    for (int i = 0; i < k + n; i++)
      slot(i == 0, (i < k) ? 1'b1 : 1'((val >> (n - 1 - (i - k))) & 1));
  endtask

  task automatic read_lo();
    @(negedge clk); rd_i = 1;
    @(negedge clk); rd_i = 0;
  endtask

  task automatic cfg(int wl, int dl, int cp, int js);
    @(negedge clk);
    wlen_i = 3'(wl); dly_i = 2'(dl); comp_i = 2'(cp); just_i = 2'(js);
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1;
    // R10 reset state
    chk("R10", "ready", rx_ready, 0); chk("R10", "ovr", rx_overrun, 0);
    chk("R10", "lo", dout_lo, 0);     chk("R10", "hi", dout_hi, 0);

    cur_req = "R1"; cfg(2, 1, 0, 0);
    send(64'hA5C3, 16, 1); idle(3);
    chk("R4", "ready", rx_ready, 1); chk("R1", "lo", dout_lo, 16'hA5C3);
    read_lo(); chk("R5", "ready after read", rx_ready, 0);
    cur_req = "R5"; read_lo(); idle(2);
    chk("R5", "idle read ready", rx_ready, 0); chk("R5", "idle read lo", dout_lo, 16'hA5C3);

    cur_req = "R7"; cfg(1, 0, 0, 1);
    send(64'h9AB, 12, 0); idle(3);
    chk("R7", "sign extend 12", dout_lo, 16'hF9AB); read_lo();
    cfg(0, 2, 0, 2); send(64'h81, 8, 2); idle(3);
    chk("R7", "left justify 8", dout_lo, 16'h8100); read_lo();
    cur_req = "R1"; cfg(0, 3, 0, 0); send(64'h3C, 8, 2); idle(3);
    chk("R1", "delay code 3", dout_lo, 16'h003C); read_lo();

    cur_req = "R2"; cfg(4, 1, 0, 1); send(64'h800001, 24, 1); idle(3);
    chk("R2", "24 hi", dout_hi, 16'hFF80); chk("R2", "24 lo", dout_lo, 16'h0001); read_lo();
    cfg(5, 1, 0, 0); send(64'hDEADBEEF, 32, 1); idle(3);
    chk("R2", "32 hi", dout_hi, 16'hDEAD); read_lo();
    cfg(7, 0, 0, 3); send(64'h13572468, 32, 0); idle(3);
    chk("R2", "code 7 lo", dout_lo, 16'h2468); read_lo();
    cur_req = "R7"; cfg(3, 1, 0, 2); send(64'hABCDE, 20, 1); idle(3);
    chk("R7", "left justify 20 hi", dout_hi, 16'hABCD);
    chk("R7", "left justify 20 lo", dout_lo, 16'hE000); read_lo();

    cur_req = "R6"; cfg(0, 1, 2, 0);
    send(64'h00, 8, 1); idle(3); chk("R6", "mu 00", dout_lo, 16'h8284); read_lo();
    send(64'hFF, 8, 1); idle(3); chk("R6", "mu FF", dout_lo, 16'h0000); read_lo();
    cfg(0, 1, 3, 0);
    send(64'hD5, 8, 1); idle(3); chk("R6", "A D5", dout_lo, 16'h0008); read_lo();
    send(64'h55, 8, 1); idle(3); chk("R6", "A 55", dout_lo, 16'hFFF8);
    chk("R6", "A hi", dout_hi, 0); read_lo();

    cur_req = "R3"; cfg(2, 1, 0, 0);
    send(64'h1111, 16, 1); send(64'h2222, 16, 1); send(64'h3333, 16, 1); idle(3);
    chk("R3", "overrun set", rx_overrun, 1); chk("R3", "first kept", dout_lo, 16'h1111);
    read_lo(); idle(2); chk("R3", "second next", dout_lo, 16'h2222);
    read_lo(); idle(2); chk("R3", "third dropped", rx_ready, 0);
    @(negedge clk); clr_i = 1; @(negedge clk); clr_i = 0;
    chk("R3", "overrun cleared", rx_overrun, 0);

    cur_req = "R8"; cfg(5, 1, 0, 0);
    send(64'hAAAA0001, 32, 1); send(64'h55550002, 32, 1); idle(6);
    chk("R8", "hi held", dout_hi, 16'hAAAA);
    read_lo(); idle(2); chk("R8", "hi replaced", dout_hi, 16'h5555); read_lo();

    cur_req = "R9"; cfg(2, 1, 0, 0);
    for (int i = 0; i < 6; i++) slot(i == 0, 1'b1);
    send(64'h1234, 16, 1); idle(3);
    chk("R9", "restart", dout_lo, 16'h1234); read_lo(); idle(4);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule